// File: doc/BRIEF.md
# Panel Power Rail Sequencer

This block turns a power-on request and a power-off request into ordered enables for a display panel's supply rails. On power-up it enables the logic supply, the analogue supply and the panel input drivers together. After a delay it releases the panel reset. After further delays it enables the negative gate supply and then the positive gate supply. Every delay is a parameter counted in system clock cycles.

On power-down the block first asks the external timing generator to show white frames. It counts a set number of completed frames from that generator, then removes the rails in reverse order. It drops the positive gate supply first, then the negative gate supply, then the logic, analogue and input enables. Only after that does it assert the panel reset, which it then holds low for a minimum time before it accepts a new power-up.

A request that arrives while a sequence is running is held until that sequence finishes. Two flags report the state: `on` means the panel is fully powered and idle, and `busy` means a sequence is in progress.

Top module: `pnl_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a power-on request, all rail enables, `white_req`, `busy` and `on` are 0 and `panel_rst_n` is 0.
- R2: A one-cycle `pwr_on_req` pulse sampled on clock edge N raises `en_logic`, `en_analog` and `en_inputs` together on edge N+1. These three enables are equal at every cycle.
- R3: `panel_rst_n` rises exactly `UP_RST` cycles after the supply enables rise. While it is low it stays low for at least `UP_RST` consecutive cycles.
- R4: `en_vneg` rises exactly `UP_NEG` cycles after `panel_rst_n` rises.
- R5: `en_vpos` rises exactly `UP_POS` cycles after `en_vneg`. On that same edge `on` becomes 1 and `busy` becomes 0.
- R6: A `pwr_off_req` pulse sampled on edge N while `on` is 1 raises `white_req` on edge N+1, with `busy`=1 and `on`=0. `en_vpos` falls on the edge that samples the `WHITE_FRAMES`-th `frame_end` pulse after that. `frame_end` pulses seen at any other time have no effect.
- R7: After `en_vpos` falls, `en_vneg` falls `DN_NEG` cycles later. The supply enables fall `DN_SUP` cycles after that, and `panel_rst_n` falls `DN_RST` cycles after the supplies. Reset is never asserted while any supply enable is still 1.
- R8: After `panel_rst_n` falls, `busy` stays 1 for exactly `RST_HOLD` cycles, and then the block is idle and off.
- R9: A power-off request that arrives during power-up does not shorten the power-up. The full power-up completes, `on` is 1 for exactly one cycle, and then `white_req` rises. `white_req` only ever rises out of the fully-on state.
- R10: A power-on request that arrives during power-down is served after the power-down completes: the supplies rise one cycle after the idle state is reached, which is `RST_HOLD`+1 cycles after reset falls. A power-on request while fully on, or a power-off request while off, is dropped and is not remembered.
- R11: `en_vpos` is 1 only while `en_vneg` is 1. `en_vneg` is 1 only while `panel_rst_n` and the supply enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pwr_on_req | input | 1 | Power-up request pulse |
| pwr_off_req | input | 1 | Power-down request pulse |
| frame_end | input | 1 | One-cycle pulse from the timing generator at the end of each white frame |
| white_req | output | 1 | Asks the timing generator to output white frames |
| en_logic | output | 1 | Logic supply enable |
| en_analog | output | 1 | Analogue supply enable |
| en_inputs | output | 1 | Enable for the panel's input signal drivers |
| panel_rst_n | output | 1 | Panel reset, active low |
| en_vneg | output | 1 | Negative gate supply enable |
| en_vpos | output | 1 | Positive gate supply enable |
| busy | output | 1 | A sequence is in progress |
| on | output | 1 | Panel fully powered and idle |

## Verification
The bench builds the block with the window check turned off and every delay set to a few cycles: `UP_RST`=5, `UP_NEG`=3, `UP_POS`=4, `DN_NEG`=2, `DN_SUP`=3, `DN_RST`=2, `RST_HOLD`=4, and `WHITE_FRAMES`=2. With these values a full power cycle takes a few dozen clocks, so every step interval can be timed exactly against its parameter. The bench repeats the cycle with several frame spacings. The same small setting also reaches the corner cases: the one-cycle on state when a power-off request is deferred, and a power-up that is queued behind a power-down.

// File: rtl/pnl_pwr_pkg.sv
package pnl_pwr_pkg;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_UP_SUP,
      ST_UP_NEG,
      ST_UP_POS,
      ST_ON,
      ST_DN_FLUSH,
      ST_DN_POS,
      ST_DN_NEG,
      ST_DN_SUP,
      ST_RST_HOLD
   } seq_state_t;

   typedef struct packed {
      logic sup;
      logic rst_rel;
      logic vneg;
      logic vpos;
      logic white;
      logic busy;
      logic on;
   } rail_ctl_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Moore decode: what each state drives onto the rails.
   function automatic rail_ctl_t state_ctl(input seq_state_t s);
      rail_ctl_t c;
      c = '0;
      case (s)
         ST_UP_SUP: begin
            c.sup = 1'b1; c.busy = 1'b1;
         end
         ST_UP_NEG: begin
            c.sup = 1'b1; c.rst_rel = 1'b1; c.busy = 1'b1;
         end
         ST_UP_POS: begin
            c.sup = 1'b1; c.rst_rel = 1'b1; c.vneg = 1'b1; c.busy = 1'b1;
         end
         ST_ON: begin
            c.sup = 1'b1; c.rst_rel = 1'b1; c.vneg = 1'b1; c.vpos = 1'b1; c.on = 1'b1;
         end
         ST_DN_FLUSH: begin
            c.sup = 1'b1; c.rst_rel = 1'b1; c.vneg = 1'b1; c.vpos = 1'b1;
            c.white = 1'b1; c.busy = 1'b1;
         end
         ST_DN_POS: begin
            c.sup = 1'b1; c.rst_rel = 1'b1; c.vneg = 1'b1; c.busy = 1'b1;
         end
         ST_DN_NEG: begin
            c.sup = 1'b1; c.rst_rel = 1'b1; c.busy = 1'b1;
         end
         ST_DN_SUP: begin
            c.rst_rel = 1'b1; c.busy = 1'b1;
         end
         ST_RST_HOLD: begin
            c.busy = 1'b1;
         end
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pnl_pwr_req.sv
module pnl_pwr_req (
   input  logic clk,
   input  logic rst_n,
   input  logic on_req,
   input  logic off_req,
   input  logic clr_on,
   input  logic clr_off,
   output logic on_pend,
   output logic off_pend
);

   localparam int NREQ = 2;

   logic [NREQ-1:0] req_v;
   logic [NREQ-1:0] clr_v;
   logic [NREQ-1:0] pend_v;

   assign req_v = {off_req, on_req};
   assign clr_v = {clr_off, clr_on};

   for (genvar i = 0; i < NREQ; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= (q | req_v[i]) & ~clr_v[i];
      end
      assign pend_v[i] = q;
   end

   assign on_pend  = pend_v[0];
   assign off_pend = pend_v[1];

   AST_OFF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (off_pend && !clr_off) |=> off_pend); // R9

endmodule

// File: rtl/pnl_pwr_timer.sv
module pnl_pwr_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          done
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - TW'(1);
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/pnl_pwr_fsm.sv
module pnl_pwr_fsm
   import pnl_pwr_pkg::*;
#(
   parameter int UP_RST       = 5,
   parameter int UP_NEG       = 3,
   parameter int UP_POS       = 4,
   parameter int DN_NEG       = 2,
   parameter int DN_SUP       = 3,
   parameter int DN_RST       = 2,
   parameter int RST_HOLD     = 4,
   parameter int WHITE_FRAMES = 2,
   parameter int TW           = 4,
   parameter int FW           = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          on_pend,
   input  logic          off_pend,
   input  logic          frame_end,
   input  logic          tmr_done,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          clr_on,
   output logic          clr_off,
   output rail_ctl_t     ctl
);

   seq_state_t    st, st_nx;
   logic [FW-1:0] fcnt;
   logic          flush_last;

   assign flush_last = frame_end && (fcnt == FW'(WHITE_FRAMES - 1));

   // Each timed state lasts exactly its delay: the timer is loaded with
   // delay-1 on entry and the state moves on when it reads zero.
   always_comb begin
      st_nx    = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st)
         ST_OFF: if (on_pend) begin
            st_nx = ST_UP_SUP; tmr_load = 1'b1; tmr_val = TW'(UP_RST - 1);
         end
         ST_UP_SUP: if (tmr_done) begin
            st_nx = ST_UP_NEG; tmr_load = 1'b1; tmr_val = TW'(UP_NEG - 1);
         end
         ST_UP_NEG: if (tmr_done) begin
            st_nx = ST_UP_POS; tmr_load = 1'b1; tmr_val = TW'(UP_POS - 1);
         end
         ST_UP_POS: if (tmr_done) st_nx = ST_ON;
         ST_ON: if (off_pend) st_nx = ST_DN_FLUSH;
         ST_DN_FLUSH: if (flush_last) begin
            st_nx = ST_DN_POS; tmr_load = 1'b1; tmr_val = TW'(DN_NEG - 1);
         end
         ST_DN_POS: if (tmr_done) begin
            st_nx = ST_DN_NEG; tmr_load = 1'b1; tmr_val = TW'(DN_SUP - 1);
         end
         ST_DN_NEG: if (tmr_done) begin
            st_nx = ST_DN_SUP; tmr_load = 1'b1; tmr_val = TW'(DN_RST - 1);
         end
         ST_DN_SUP: if (tmr_done) begin
            st_nx = ST_RST_HOLD; tmr_load = 1'b1; tmr_val = TW'(RST_HOLD - 1);
         end
         ST_RST_HOLD: if (tmr_done) st_nx = ST_OFF;
         default: st_nx = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_OFF;
      else        st <= st_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 fcnt <= '0;
      else if (st != ST_DN_FLUSH) fcnt <= '0;
      else if (frame_end)         fcnt <= fcnt + FW'(1);
   end

   // Requests that make no sense in a settled state are dropped there.
   assign clr_on  = (st == ST_ON)  || ((st == ST_OFF) && on_pend);
   assign clr_off = (st == ST_OFF) || ((st == ST_ON) && off_pend);

   assign ctl = state_ctl(st);

   // Run length of the low reset, for the width check below.
   logic [TW:0] low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               low_run <= '0;
      else if (ctl.rst_rel)     low_run <= '0;
      else if (low_run != '1)   low_run <= low_run + (TW+1)'(1);
   end

   AST_RST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.rst_rel) |-> (low_run >= (TW+1)'(UP_RST))); // R3

   AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl.vpos) |-> ($past(frame_end) && ($past(fcnt) == FW'(WHITE_FRAMES - 1)))); // R6

   AST_WHITE_FROM_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl.white) |-> ($past(st) == ST_ON)); // R9

endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
   import pnl_pwr_pkg::*;
#(
   parameter int CLK_KHZ       = 10000,
   parameter bit CHECK_WINDOWS = 1'b1,
   parameter int UP_RST        = 20000,
   parameter int UP_NEG        = 5000,
   parameter int UP_POS        = 10000,
   parameter int DN_NEG        = 5000,
   parameter int DN_SUP        = 5000,
   parameter int DN_RST        = 5000,
   parameter int RST_HOLD      = 20,
   parameter int WHITE_FRAMES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on_req,
   input  logic pwr_off_req,
   input  logic frame_end,
   output logic white_req,
   output logic en_logic,
   output logic en_analog,
   output logic en_inputs,
   output logic panel_rst_n,
   output logic en_vneg,
   output logic en_vpos,
   output logic busy,
   output logic on
);

   localparam int MAXD = max2(max2(max2(UP_RST, UP_NEG), max2(UP_POS, DN_NEG)),
                              max2(max2(DN_SUP, DN_RST), RST_HOLD));
   localparam int TW   = $clog2(MAXD + 1);
   localparam int FW   = $clog2(WHITE_FRAMES + 1);

   // Parameter sanity: every delay at least one cycle.
   if (UP_RST < 1 || UP_NEG < 1 || UP_POS < 1 || DN_NEG < 1 ||
       DN_SUP < 1 || DN_RST < 1 || RST_HOLD < 1 || WHITE_FRAMES < 1) begin : g_bad_cfg
      $error("pnl_pwr_seq: every delay and the frame count must be at least 1");
   end

   // Optional check of the delays against the panel's millisecond windows.
   if (CHECK_WINDOWS) begin : g_win
      if (UP_RST < CLK_KHZ || UP_RST > 5 * CLK_KHZ) begin : g_rst
         $error("pnl_pwr_seq: reset release delay outside 1..5 ms");
      end
      if (UP_NEG < CLK_KHZ / 10 || UP_NEG > 10 * CLK_KHZ) begin : g_neg
         $error("pnl_pwr_seq: negative gate delay outside 0.1..10 ms");
      end
      if (UP_NEG + UP_POS < (CLK_KHZ * 11) / 10 ||
          UP_NEG + UP_POS > 10 * CLK_KHZ) begin : g_pos
         $error("pnl_pwr_seq: positive gate delay outside 1.1..10 ms");
      end
      if (RST_HOLD < (CLK_KHZ + 999) / 1000) begin : g_hold
         $error("pnl_pwr_seq: reset hold shorter than 1 us");
      end
   end

   logic          on_pend, off_pend;
   logic          clr_on, clr_off;
   logic          tmr_load, tmr_done;
   logic [TW-1:0] tmr_val;
   rail_ctl_t     ctl;

   pnl_pwr_req u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .on_req   (pwr_on_req),
      .off_req  (pwr_off_req),
      .clr_on   (clr_on),
      .clr_off  (clr_off),
      .on_pend  (on_pend),
      .off_pend (off_pend)
   );

   pnl_pwr_timer #(.TW(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   pnl_pwr_fsm #(
      .UP_RST       (UP_RST),
      .UP_NEG       (UP_NEG),
      .UP_POS       (UP_POS),
      .DN_NEG       (DN_NEG),
      .DN_SUP       (DN_SUP),
      .DN_RST       (DN_RST),
      .RST_HOLD     (RST_HOLD),
      .WHITE_FRAMES (WHITE_FRAMES),
      .TW           (TW),
      .FW           (FW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_pend   (on_pend),
      .off_pend  (off_pend),
      .frame_end (frame_end),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .clr_on    (clr_on),
      .clr_off   (clr_off),
      .ctl       (ctl)
   );

   assign en_logic    = ctl.sup;
   assign en_analog   = ctl.sup;
   assign en_inputs   = ctl.sup;
   assign panel_rst_n = ctl.rst_rel;
   assign en_vneg     = ctl.vneg;
   assign en_vpos     = ctl.vpos;
   assign white_req   = ctl.white;
   assign busy        = ctl.busy;
   assign on          = ctl.on;

   AST_SUP_GANGED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_logic == en_analog) && (en_analog == en_inputs)); // R2

   AST_POS_NEEDS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      en_vpos |-> en_vneg); // R11

   AST_NEG_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
      en_vneg |-> (panel_rst_n && en_logic)); // R11

   AST_RST_AFTER_SUP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(panel_rst_n) |-> !en_logic); // R7

endmodule

// File: tb/pnl_pwr_seq_bench.sv
module pnl_pwr_seq_bench;

   localparam int UP_RST = 5, UP_NEG = 3, UP_POS = 4;
   localparam int DN_NEG = 2, DN_SUP = 3, DN_RST = 2, RST_HOLD = 4;
   localparam int WF = 2;
   localparam int WDOG = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, frame_end = 1'b0;
   logic white_req, en_logic, en_analog, en_inputs, panel_rst_n;
   logic en_vneg, en_vpos, busy, on;

   always #2.5 clk = ~clk;

   pnl_pwr_seq #(
      .CLK_KHZ(200000), .CHECK_WINDOWS(1'b0),
      .UP_RST(UP_RST), .UP_NEG(UP_NEG), .UP_POS(UP_POS),
      .DN_NEG(DN_NEG), .DN_SUP(DN_SUP), .DN_RST(DN_RST),
      .RST_HOLD(RST_HOLD), .WHITE_FRAMES(WF)
   ) u_pnl_pwr_seq (
      .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
      .frame_end(frame_end), .white_req(white_req), .en_logic(en_logic),
      .en_analog(en_analog), .en_inputs(en_inputs), .panel_rst_n(panel_rst_n),
      .en_vneg(en_vneg), .en_vpos(en_vpos), .busy(busy), .on(on)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   int t_sup_r, t_sup_f, t_rst_r, t_rst_f, t_neg_r, t_neg_f;
   int t_pos_r, t_pos_f, t_on_r, t_busy_f, t_wr_r;
   logic p_sup = 0, p_rst = 0, p_neg = 0, p_pos = 0, p_on = 0, p_busy = 0, p_wr = 0;

   // Edge-time monitor: runs 1 ns after each rising edge, away from the bench stimulus.
   always begin
      @(posedge clk);
      #1;
      cyc++;
      if (en_logic && !p_sup)    t_sup_r = cyc;
      if (!en_logic && p_sup)    t_sup_f = cyc;
      if (panel_rst_n && !p_rst) t_rst_r = cyc;
      if (!panel_rst_n && p_rst) t_rst_f = cyc;
      if (en_vneg && !p_neg)     t_neg_r = cyc;
      if (!en_vneg && p_neg)     t_neg_f = cyc;
      if (en_vpos && !p_pos)     t_pos_r = cyc;
      if (!en_vpos && p_pos)     t_pos_f = cyc;
      if (on && !p_on)           t_on_r = cyc;
      if (!busy && p_busy)       t_busy_f = cyc;
      if (white_req && !p_wr)    t_wr_r = cyc;
      p_sup = en_logic; p_rst = panel_rst_n; p_neg = en_vneg; p_pos = en_vpos;
      p_on = on; p_busy = busy; p_wr = white_req;
      if (cyc > WDOG) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse_on(output int t);
      @(negedge clk); pwr_on_req = 1'b1;
      @(negedge clk); pwr_on_req = 1'b0; t = cyc;
   endtask

   task automatic pulse_off(output int t);
      @(negedge clk); pwr_off_req = 1'b1;
      @(negedge clk); pwr_off_req = 1'b0; t = cyc;
   endtask

   task automatic pulse_frame(output int t);
      @(negedge clk); frame_end = 1'b1;
      @(negedge clk); frame_end = 1'b0; t = cyc;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_on();
      while (!on) @(negedge clk);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   // Sends the white frames with the given spacing; returns the edge of the last one.
   task automatic flush(input int gap, output int t_last);
      int t;
      t = 0;
      for (int k = 0; k < WF; k++) begin
         idle(gap);
         pulse_frame(t);
         if (k < WF - 1) chk(en_vpos == 1'b1, "R6 vpos held before last frame", int'(en_vpos), 1);
      end
      t_last = t;
   endtask

   task automatic check_up(input int t_req);
      chk(t_sup_r - t_req == 1, "R2 supply latency", t_sup_r - t_req, 1);
      chk(t_rst_r - t_sup_r == UP_RST, "R3 reset release delay", t_rst_r - t_sup_r, UP_RST);
      chk(t_neg_r - t_rst_r == UP_NEG, "R4 vneg delay", t_neg_r - t_rst_r, UP_NEG);
      chk(t_pos_r - t_neg_r == UP_POS, "R5 vpos delay", t_pos_r - t_neg_r, UP_POS);
   endtask

   task automatic check_down(input int t_last);
      chk(t_pos_f == t_last, "R6 vpos off at last frame", t_pos_f, t_last);
      chk(t_neg_f - t_pos_f == DN_NEG, "R7 vneg off delay", t_neg_f - t_pos_f, DN_NEG);
      chk(t_sup_f - t_neg_f == DN_SUP, "R7 supply off delay", t_sup_f - t_neg_f, DN_SUP);
      chk(t_rst_f - t_sup_f == DN_RST, "R7 reset assert delay", t_rst_f - t_sup_f, DN_RST);
      chk(t_busy_f - t_rst_f == RST_HOLD, "R8 reset hold", t_busy_f - t_rst_f, RST_HOLD);
   endtask

   initial begin
      int t_req, t_off, t_last;
      idle(3);
      // R1: reset state
      chk({en_logic, en_analog, en_inputs, panel_rst_n, en_vneg, en_vpos,
           white_req, busy, on} == 9'b0, "R1 outputs in reset",
          int'({en_logic, panel_rst_n, en_vneg, en_vpos, busy, on}), 0);
      rst_n = 1'b1;
      idle(4);
      chk({en_logic, panel_rst_n, en_vpos, busy, on} == 5'b0, "R1 idle after reset",
          int'({en_logic, panel_rst_n, en_vpos, busy, on}), 0);

      // Full cycles over several frame spacings.
      for (int gap = 0; gap < 4; gap++) begin
         pulse_on(t_req);
         wait_on();
         idle(1);
         check_up(t_req);
         chk(on && !busy, "R5 on flag", int'({on, busy}), 2);
         chk(en_vneg && panel_rst_n && en_analog && en_inputs, "R11 rails under vpos",
             int'({en_vneg, panel_rst_n, en_analog, en_inputs}), 15);
         if (gap == 0) begin
            pulse_on(t_req);
            idle(5);
            chk(en_vpos && !white_req && !busy, "R10 on request while on dropped",
                int'({en_vpos, white_req, busy}), 4);
         end
         pulse_frame(t_last);
         idle(3);
         chk(en_vpos && !white_req, "R6 stray frame ignored", int'({en_vpos, white_req}), 2);
         pulse_off(t_off);
         idle(1);
         chk(t_wr_r - t_off == 1, "R6 white request latency", t_wr_r - t_off, 1);
         chk(busy && !on, "R6 flags during flush", int'({busy, on}), 2);
         flush(gap, t_last);
         wait_idle();
         check_down(t_last);
      end

      // R9: off request during power-up is deferred.
      pulse_on(t_req);
      while (!panel_rst_n) @(negedge clk);
      pulse_off(t_off);
      while (!white_req) @(negedge clk);
      idle(1);
      check_up(t_req);
      chk(t_wr_r - t_on_r == 1, "R9 on for one cycle", t_wr_r - t_on_r, 1);
      flush(1, t_last);
      wait_idle();
      check_down(t_last);

      // R10: on request during power-down is queued.
      pulse_on(t_req);
      wait_on();
      pulse_off(t_off);
      flush(2, t_last);
      pulse_on(t_req);
      chk(en_logic == 1'b1, "R10 request sent during power-down", int'(en_logic), 1);
      wait_on();
      idle(1);
      chk(t_sup_r - t_rst_f == RST_HOLD + 1, "R10 deferred restart", t_sup_r - t_rst_f, RST_HOLD + 1);
      chk(t_rst_r - t_sup_r == UP_RST, "R3 restart reset delay", t_rst_r - t_sup_r, UP_RST);

      // R10: off request while off is dropped.
      pulse_off(t_off);
      flush(1, t_last);
      wait_idle();
      pulse_off(t_off);
      idle(8);
      chk(!en_logic && !busy, "R10 off while off stays off", int'({en_logic, busy}), 0);
      pulse_on(t_req);
      wait_on();
      idle(6);
      chk(on && !white_req, "R10 stale off not remembered", int'({on, white_req}), 2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule